// File: doc/BRIEF.md
# Serial Link Start-Up and Flow-Control Controller

This block sequences a point-to-point serial link from power-up to normal traffic. After reset it holds the receiver and transmitter off for a fixed hold time. It then enables the receiver and waits for twice that time before it will accept a start request. It brings the transmitter up in two steps. The first step allows only idle (NULL) characters. The second step also allows flow-control tokens (FCT). Once the first FCT arrives from the far end, the link enters normal running.

In the running state the block keeps two credit counts. The transmit credit is the number of data characters the far end has room for. It rises by eight for each received FCT and falls by one for each data character sent. The receive credit is the room already granted to the far end. It rises by eight for each FCT sent and falls by one for each data character received. The block asks the transmitter for a new FCT whenever the host's receive-buffer room covers the outstanding credit plus eight more characters.

Any run-time fault sends the link back through the timed reset and reconnect path, and pulses a one-cycle status flag for the host. Faults include a disconnect, a parity error, an escape error and a credit violation. Time codes and data characters pass straight through between the host and the character transmitter or receiver, but only while the link is running.

Top module: `lnk_init_ctrl`

## Requirements
- R1: After reset the block is in the hold state. rx_en_o, tx_en_o, started_o, connecting_o and running_o are all low. While in the hold state, rx_char_o stays low even if rx_char_i is high.
- R2: The hold state lasts exactly RESET_CYC clocks after reset release. rx_en_o is low after RESET_CYC-1 rising edges and high after RESET_CYC edges.
- R3: The block leaves the idle-ready state for the NULL-only state only when all of these hold: link_dis_i is low, rx_room_i is at least 8, and either link_start_i is high or auto_start_i and got_null_i are both high. In every other case none of the three status outputs rises.
- R4: In the NULL-only state, started_o, tx_en_o and tx_null_only_o are high. A high got_null_i moves the block to the token state. Without it, the block returns to the hold state after exactly 2*RESET_CYC clocks.
- R5: In the token state, connecting_o, tx_en_o and tx_fct_only_o are high. A got_fct_i pulse moves the block to running (running_o high) on the next clock.
- R6: Each got_fct_i pulse in the token or running state adds 8 to the transmit credit. A pulse that would take the credit above 56 raises err_cred_o for one clock and drops the link.
- R7: tx_nchar_req_o equals tx_req_i only while the block is running and the transmit credit is nonzero. Each clock with tx_nchar_req_o and tx_ack_i both high takes one from the credit.
- R8: fct_req_o is high in the token or running state when rx_room_i >= receive credit + 8 and the receive credit is at most 48. Each clock with fct_req_o and fct_ack_i both high adds 8 to the receive credit.
- R9: An rx_char_i pulse while running with zero receive credit raises err_cred_o for one clock and drops the link.
- R10: An rx_disc_i, rx_par_i or rx_esc_i pulse while running raises the matching err_*_o flag for exactly one clock, and running_o is low on the next clock.
- R11: link_dis_i high while the link is in the NULL-only, token or running state drops it. On the next clock all three status outputs are low.
- R12: At most one of started_o, connecting_o and running_o is high at any time.
- R13: rx_char_o, rx_flag_o and rx_data_o pass the receiver's character outputs to the host while the block is running. tick_o and tc_o do the same for received time codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_start_i | input | 1 | Forced start request |
| auto_start_i | input | 1 | Start on receipt of a NULL |
| link_dis_i | input | 1 | Disable; overrides start and drops an active link |
| rx_room_i | input | ROOM_W | Free receive-buffer room in characters |
| tx_req_i | input | 1 | Host requests to send a data character |
| tx_flag_i | input | 1 | Control flag of the host character |
| tx_data_i | input | DATA_W | Host character byte |
| tx_ack_o | output | 1 | Character accepted by the transmitter |
| tick_i | input | 1 | Host time-code request |
| tc_i | input | TC_W | Host time-code value |
| started_o | output | 1 | NULL-only state |
| connecting_o | output | 1 | Token state |
| running_o | output | 1 | Running state |
| err_disc_o | output | 1 | Disconnect fault pulse |
| err_par_o | output | 1 | Parity fault pulse |
| err_esc_o | output | 1 | Escape fault pulse |
| err_cred_o | output | 1 | Credit fault pulse |
| rx_char_o | output | 1 | Received character strobe to host |
| rx_flag_o | output | 1 | Received character control flag |
| rx_data_o | output | DATA_W | Received character byte |
| tick_o | output | 1 | Received time-code strobe |
| tc_o | output | TC_W | Received time-code value |
| rx_en_o | output | 1 | Receiver enable |
| got_null_i | input | 1 | Receiver has seen a NULL since enable (level) |
| got_fct_i | input | 1 | FCT received (pulse) |
| rx_char_i | input | 1 | Character received (pulse) |
| rx_flag_i | input | 1 | Received control flag |
| rx_data_i | input | DATA_W | Received byte |
| rx_tick_i | input | 1 | Time code received (pulse) |
| rx_tc_i | input | TC_W | Received time-code value |
| rx_disc_i | input | 1 | Receiver disconnect fault |
| rx_par_i | input | 1 | Receiver parity fault |
| rx_esc_i | input | 1 | Receiver escape fault |
| tx_en_o | output | 1 | Transmitter enable |
| tx_null_only_o | output | 1 | Transmitter may send only NULLs |
| tx_fct_only_o | output | 1 | Transmitter may send only NULLs and FCTs |
| fct_req_o | output | 1 | Request to send an FCT |
| fct_ack_i | input | 1 | FCT sent |
| tx_tick_o | output | 1 | Time-code request to transmitter |
| tx_tc_o | output | TC_W | Time-code value to transmitter |
| tx_nchar_req_o | output | 1 | Data character request to transmitter |
| tx_flag_o | output | 1 | Control flag to transmitter |
| tx_data_o | output | DATA_W | Byte to transmitter |
| tx_ack_i | input | 1 | Transmitter accepted the character |

## Verification
The bench probes the start gate with every mix of the start inputs, disable and room. The room values include 7 and 8, the edge of the start threshold. A gate that ignored room or disable would raise a status output where none is allowed. It times the hold state and the NULL-only timeout to the exact clock, so an off-by-one counter fails. It drains the transmit credit to zero and then pushes it one FCT past 56, so a missing credit gate keeps requesting characters and a missing overflow check keeps running. It also grants receive credit until the FCT request must stop, and it sends a character with no credit granted, which must raise the credit fault.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SETTLE,
    ST_READY,
    ST_NULLS,
    ST_TOKENS,
    ST_RUN
  } lnk_state_e;
endpackage

// File: rtl/lnk_timer.sv
module lnk_timer #(
  parameter int RESET_CYC = 640
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic hold_done_o,
  output logic long_done_o
);
  localparam int CW = $clog2(2 * RESET_CYC);
  localparam logic [CW-1:0] HOLD_LAST = CW'(RESET_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST = CW'(2 * RESET_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q != LONG_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_done_o = (cnt_q == HOLD_LAST);
  assign long_done_o = (cnt_q == LONG_LAST);
endmodule

// File: rtl/lnk_credit.sv
module lnk_credit #(
  parameter int STEP = 8,
  parameter int MAX  = 56
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clr_i,
  input  logic                               add_i,
  input  logic                               sub_i,
  output logic [$clog2(MAX+STEP+1)-1:0]      cnt_o,
  output logic                               ovf_o,
  output logic                               unf_o
);
  localparam int W = $clog2(MAX + STEP + 1);
  localparam logic [W-1:0] STEP_V = W'(STEP);
  localparam logic [W-1:0] MAX_V  = W'(MAX);

  logic [W-1:0] cnt_q, cnt_d;

  assign ovf_o = add_i && ((cnt_q + STEP_V) > MAX_V);
  assign unf_o = sub_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (add_i && !ovf_o) cnt_d = cnt_d + STEP_V;
    if (sub_i && !unf_o) cnt_d = cnt_d - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lnk_fsm.sv
module lnk_fsm
  import lnk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_start_i,
  input  logic       auto_start_i,
  input  logic       link_dis_i,
  input  logic       room_ok_i,
  input  logic       got_null_i,
  input  logic       got_fct_i,
  input  logic       rx_char_i,
  input  logic       rx_tick_i,
  input  logic       rx_fault_i,
  input  logic       cred_err_i,
  input  logic       hold_done_i,
  input  logic       long_done_i,
  output lnk_state_e state_o,
  output logic       chg_o
);
  lnk_state_e st_q, st_d;
  logic       stray, stray_fct;

  // events that must not occur before the link runs
  assign stray     = rx_fault_i | rx_char_i | rx_tick_i;
  assign stray_fct = stray | got_fct_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:   if (hold_done_i) st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (stray_fct)        st_d = ST_HOLD;
        else if (long_done_i) st_d = ST_READY;
      end
      ST_READY: begin
        if (stray_fct) st_d = ST_HOLD;
        else if (!link_dis_i && room_ok_i &&
                 (link_start_i || (auto_start_i && got_null_i)))
          st_d = ST_NULLS;
      end
      ST_NULLS: begin
        if (stray_fct || link_dis_i || long_done_i) st_d = ST_HOLD;
        else if (got_null_i)                        st_d = ST_TOKENS;
      end
      ST_TOKENS: begin
        if (stray || link_dis_i || long_done_i) st_d = ST_HOLD;
        else if (got_fct_i)                     st_d = ST_RUN;
      end
      ST_RUN:    if (rx_fault_i || cred_err_i || link_dis_i) st_d = ST_HOLD;
      default:   st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HOLD;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign chg_o   = (st_d != st_q);
endmodule

// File: rtl/lnk_init_ctrl.sv
module lnk_init_ctrl
  import lnk_pkg::*;
#(
  parameter int RESET_CYC = 640,
  parameter int ROOM_W    = 6,
  parameter int DATA_W    = 8,
  parameter int TC_W      = 8,
  parameter int CRED_STEP = 8,
  parameter int CRED_MAX  = 56,
  parameter int MIN_ROOM  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_start_i,
  input  logic              auto_start_i,
  input  logic              link_dis_i,
  input  logic [ROOM_W-1:0] rx_room_i,
  input  logic              tx_req_i,
  input  logic              tx_flag_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ack_o,
  input  logic              tick_i,
  input  logic [TC_W-1:0]   tc_i,
  output logic              started_o,
  output logic              connecting_o,
  output logic              running_o,
  output logic              err_disc_o,
  output logic              err_par_o,
  output logic              err_esc_o,
  output logic              err_cred_o,
  output logic              rx_char_o,
  output logic              rx_flag_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tick_o,
  output logic [TC_W-1:0]   tc_o,
  output logic              rx_en_o,
  input  logic              got_null_i,
  input  logic              got_fct_i,
  input  logic              rx_char_i,
  input  logic              rx_flag_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_tick_i,
  input  logic [TC_W-1:0]   rx_tc_i,
  input  logic              rx_disc_i,
  input  logic              rx_par_i,
  input  logic              rx_esc_i,
  output logic              tx_en_o,
  output logic              tx_null_only_o,
  output logic              tx_fct_only_o,
  output logic              fct_req_o,
  input  logic              fct_ack_i,
  output logic              tx_tick_o,
  output logic [TC_W-1:0]   tx_tc_o,
  output logic              tx_nchar_req_o,
  output logic              tx_flag_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ack_i
);
  localparam int CW = $clog2(CRED_MAX + CRED_STEP + 1);
  localparam int RW = ((CW > ROOM_W) ? CW : ROOM_W) + 1;
  localparam logic [RW-1:0] STEP_R    = RW'(CRED_STEP);
  localparam logic [RW-1:0] MAX_R     = RW'(CRED_MAX);
  localparam logic [RW-1:0] MIN_ROOM_R = RW'(MIN_ROOM);

  lnk_state_e st;
  logic       st_chg, hold_done, long_done;
  logic       in_run, in_tok, in_nul, cred_live;
  logic       rx_fault, cred_err;
  logic [CW-1:0] tx_cred, rx_cred;
  logic       tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [RW-1:0] room_x, rx_need;
  logic       err_disc_q, err_par_q, err_esc_q, err_cred_q;

  assign in_run    = (st == ST_RUN);
  assign in_tok    = (st == ST_TOKENS);
  assign in_nul    = (st == ST_NULLS);
  assign cred_live = in_run | in_tok;
  assign rx_fault  = rx_disc_i | rx_par_i | rx_esc_i;
  assign cred_err  = in_run & (tx_ovf | tx_unf | rx_ovf | rx_unf);

  assign room_x  = RW'(rx_room_i);
  assign rx_need = RW'(rx_cred) + STEP_R;

  lnk_timer #(.RESET_CYC(RESET_CYC)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (st_chg),
    .hold_done_o (hold_done),
    .long_done_o (long_done)
  );

  lnk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .link_start_i (link_start_i),
    .auto_start_i (auto_start_i),
    .link_dis_i   (link_dis_i),
    .room_ok_i    (room_x >= MIN_ROOM_R),
    .got_null_i   (got_null_i),
    .got_fct_i    (got_fct_i),
    .rx_char_i    (rx_char_i),
    .rx_tick_i    (rx_tick_i),
    .rx_fault_i   (rx_fault),
    .cred_err_i   (cred_err),
    .hold_done_i  (hold_done),
    .long_done_i  (long_done),
    .state_o      (st),
    .chg_o        (st_chg)
  );

  // transmit credit: what the far end can still accept
  lnk_credit #(.STEP(CRED_STEP), .MAX(CRED_MAX)) u_tx_cred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!cred_live),
    .add_i  (got_fct_i & cred_live),
    .sub_i  (tx_nchar_req_o & tx_ack_i),
    .cnt_o  (tx_cred),
    .ovf_o  (tx_ovf),
    .unf_o  (tx_unf)
  );

  // receive credit: room already granted to the far end
  lnk_credit #(.STEP(CRED_STEP), .MAX(CRED_MAX)) u_rx_cred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!cred_live),
    .add_i  (fct_req_o & fct_ack_i),
    .sub_i  (rx_char_i & in_run),
    .cnt_o  (rx_cred),
    .ovf_o  (rx_ovf),
    .unf_o  (rx_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_disc_q <= 1'b0;
      err_par_q  <= 1'b0;
      err_esc_q  <= 1'b0;
      err_cred_q <= 1'b0;
    end else begin
      err_disc_q <= in_run & rx_disc_i;
      err_par_q  <= in_run & rx_par_i;
      err_esc_q  <= in_run & rx_esc_i;
      err_cred_q <= cred_err;
    end
  end

  assign err_disc_o = err_disc_q;
  assign err_par_o  = err_par_q;
  assign err_esc_o  = err_esc_q;
  assign err_cred_o = err_cred_q;

  assign started_o    = in_nul;
  assign connecting_o = in_tok;
  assign running_o    = in_run;

  assign rx_en_o        = (st != ST_HOLD);
  assign tx_en_o        = in_nul | cred_live;
  assign tx_null_only_o = in_nul;
  assign tx_fct_only_o  = in_tok;

  assign fct_req_o = cred_live && (room_x >= rx_need) && (rx_need <= MAX_R);

  assign tx_nchar_req_o = in_run & tx_req_i & (tx_cred != '0);
  assign tx_ack_o       = tx_nchar_req_o & tx_ack_i;
  assign tx_flag_o      = tx_flag_i;
  assign tx_data_o      = tx_data_i;
  assign tx_tick_o      = in_run & tick_i;
  assign tx_tc_o        = tc_i;

  assign rx_char_o = in_run & rx_char_i;
  assign rx_flag_o = rx_flag_i;
  assign rx_data_o = rx_data_i;
  assign tick_o    = in_run & rx_tick_i;
  assign tc_o      = rx_tc_i;
endmodule

// File: rtl/lnk_init_ctrl_chk.sv
module lnk_init_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic started_o,
  input logic connecting_o,
  input logic running_o,
  input logic err_par_o,
  input logic err_cred_o,
  input logic rx_par_i,
  input logic link_dis_i,
  input logic fct_req_o,
  input logic tx_nchar_req_o,
  input logic rx_en_o,
  input logic tx_en_o
);
  // R12
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({started_o, connecting_o, running_o}));

  // R7
  nchar_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_nchar_req_o |-> running_o);

  // R10
  par_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_par_o |=> !err_par_o);

  // R10
  par_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && rx_par_i) |=> (!running_o && err_par_o));

  // R11
  dis_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_dis_i |=> !(started_o || connecting_o || running_o));

  // R6
  cred_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cred_o |-> !running_o);

  // R8
  fct_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fct_req_o |-> (connecting_o || running_o));

  // R1
  en_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_o |-> !tx_en_o);
endmodule

bind lnk_init_ctrl lnk_init_ctrl_chk u_chk (.*);

// File: tb/lnk_init_ctrl_bench.sv
module lnk_init_ctrl_bench;
  localparam int RC = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic link_start = 0, auto_start = 0, link_dis = 0;
  logic [5:0] room = 6'd63;
  logic tx_req = 0, tx_flag = 0, tick = 0;
  logic [7:0] tx_data = 8'h00, tc = 8'h00;
  logic got_null = 0, got_fct = 0, rx_char = 0, rx_flag = 0, rx_tick = 0;
  logic [7:0] rx_data = 8'h00, rx_tc = 8'h00;
  logic rx_disc = 0, rx_par = 0, rx_esc = 0, fct_ack = 0, tx_ack = 0;

  logic tx_ack_o, started, connecting, running;
  logic err_disc, err_par, err_esc, err_cred;
  logic rx_char_o, rx_flag_o, tick_o, rx_en, tx_en, tx_null_only, tx_fct_only;
  logic fct_req, tx_tick_o, tx_nchar_req, tx_flag_o;
  logic [7:0] rx_data_o, tc_o, tx_tc_o, tx_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lnk_init_ctrl #(.RESET_CYC(RC)) u_lnk_init_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .link_start_i(link_start), .auto_start_i(auto_start), .link_dis_i(link_dis),
    .rx_room_i(room), .tx_req_i(tx_req), .tx_flag_i(tx_flag), .tx_data_i(tx_data),
    .tx_ack_o(tx_ack_o), .tick_i(tick), .tc_i(tc),
    .started_o(started), .connecting_o(connecting), .running_o(running),
    .err_disc_o(err_disc), .err_par_o(err_par), .err_esc_o(err_esc), .err_cred_o(err_cred),
    .rx_char_o(rx_char_o), .rx_flag_o(rx_flag_o), .rx_data_o(rx_data_o),
    .tick_o(tick_o), .tc_o(tc_o), .rx_en_o(rx_en),
    .got_null_i(got_null), .got_fct_i(got_fct), .rx_char_i(rx_char), .rx_flag_i(rx_flag),
    .rx_data_i(rx_data), .rx_tick_i(rx_tick), .rx_tc_i(rx_tc),
    .rx_disc_i(rx_disc), .rx_par_i(rx_par), .rx_esc_i(rx_esc),
    .tx_en_o(tx_en), .tx_null_only_o(tx_null_only), .tx_fct_only_o(tx_fct_only),
    .fct_req_o(fct_req), .fct_ack_i(fct_ack), .tx_tick_o(tx_tick_o), .tx_tc_o(tx_tc_o),
    .tx_nchar_req_o(tx_nchar_req), .tx_flag_o(tx_flag_o), .tx_data_o(tx_data_o),
    .tx_ack_i(tx_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ticks(2);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_fct();
    got_fct = 1'b1; ticks(1); got_fct = 1'b0;
  endtask

  task automatic bring_up(input logic [5:0] r);
    int lim;
    link_start = 1; auto_start = 0; link_dis = 0; got_null = 1; room = r;
    do_reset();
    lim = 0;
    while (!connecting && lim < 200) begin ticks(1); lim++; end
    pulse_fct();
  endtask

  // {link_start, auto_start, link_dis, got_null, room[5:0], expect_leave}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd63, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 6'd63, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 6'd63, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 6'd63, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 6'd7,  1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd8,  1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 6'd63, 1'b0}
  };

  initial begin
    // R1 reset state
    do_reset();
    ticks(1);
    chk(!rx_en && !tx_en && !started && !connecting && !running, "R1 reset outputs",
        {rx_en, tx_en, started, connecting, running}, 0);
    rx_char = 1; #1;
    chk(rx_char_o == 0, "R1 rx_char_o in hold", rx_char_o, 0);
    rx_char = 0;

    // R2 hold length
    do_reset();
    ticks(RC - 1);
    chk(rx_en == 0, "R2 rx_en before hold end", rx_en, 0);
    ticks(1);
    chk(rx_en == 1, "R2 rx_en after hold end", rx_en, 1);

    // R3 start gating table
    for (int i = 0; i < NV; i++) begin
      {link_start, auto_start, link_dis, got_null, room} = VEC[i][10:1];
      do_reset();
      ticks(32);
      chk((started | connecting | running) == VEC[i][0], $sformatf("R3 vector %0d", i),
          started | connecting | running, VEC[i][0]);
    end
    link_dis = 0;

    // R4 NULL-only timeout
    link_start = 1; auto_start = 0; got_null = 0; room = 63;
    do_reset();
    begin
      int lim = 0;
      while (!started && lim < 200) begin ticks(1); lim++; end
    end
    chk(tx_en && tx_null_only && !tx_fct_only, "R4 null-only outputs",
        {tx_en, tx_null_only, tx_fct_only}, 3'b110);
    ticks(2 * RC - 1);
    chk(started == 1, "R4 still started before timeout", started, 1);
    ticks(1);
    chk(started == 0 && rx_en == 0, "R4 timeout to hold", started, 0);

    // R5 token state then run
    got_null = 1; room = 63;
    do_reset();
    begin
      int lim = 0;
      while (!connecting && lim < 200) begin ticks(1); lim++; end
    end
    chk(tx_en && tx_fct_only && !tx_null_only, "R5 token outputs",
        {tx_en, tx_fct_only, tx_null_only}, 3'b110);
    pulse_fct();
    chk(running == 1, "R5 got_fct to run", running, 1);

    // R7 credit gating: 8 credits from first FCT
    tx_req = 1; #1;
    chk(tx_nchar_req == 1, "R7 request with credit", tx_nchar_req, 1);
    tx_ack = 1;
    ticks(8);
    chk(tx_nchar_req == 0, "R7 request after 8 sent", tx_nchar_req, 0);
    tx_ack = 0; tx_req = 0;

    // R6 credit overflow: 0 + 7*8 = 56 ok, 64 overflows
    repeat (7) pulse_fct();
    chk(running == 1 && err_cred == 0, "R6 credit at 56", {running, err_cred}, 2'b10);
    pulse_fct();
    chk(err_cred == 1 && running == 0, "R6 overflow", {err_cred, running}, 2'b10);
    ticks(1);
    chk(err_cred == 0, "R6 flag clears", err_cred, 0);

    // R10 parity fault
    bring_up(6'd63);
    rx_par = 1; ticks(1); rx_par = 0;
    chk(err_par == 1 && running == 0, "R10 parity drop", {err_par, running}, 2'b10);
    ticks(1);
    chk(err_par == 0, "R10 parity clears", err_par, 0);

    // R10 disconnect fault
    bring_up(6'd63);
    rx_disc = 1; ticks(1); rx_disc = 0;
    chk(err_disc == 1 && running == 0, "R10 disconnect drop", {err_disc, running}, 2'b10);

    // R11 disable drops run
    bring_up(6'd63);
    link_dis = 1; ticks(1);
    chk(running == 0, "R11 disable drops", running, 0);
    link_dis = 0;

    // R9 character without receive credit
    bring_up(6'd63);
    rx_char = 1; ticks(1); rx_char = 0;
    chk(err_cred == 1 && running == 0, "R9 rx overrun", {err_cred, running}, 2'b10);

    // R8 fct requests up to 56 with full room
    bring_up(6'd63);
    chk(fct_req == 1, "R8 fct req at zero credit", fct_req, 1);
    fct_ack = 1; ticks(7); fct_ack = 0;
    chk(fct_req == 0, "R8 fct req stops at 56", fct_req, 0);

    // R8 room-limited, R13 pass-through
    bring_up(6'd20);
    fct_ack = 1; ticks(1);
    chk(fct_req == 1, "R8 room 20 credit 8", fct_req, 1);
    ticks(1); fct_ack = 0;
    chk(fct_req == 0, "R8 room 20 credit 16", fct_req, 0);
    rx_char = 1; rx_data = 8'hA5; rx_flag = 1; rx_tick = 1; rx_tc = 8'h3C; #1;
    chk(rx_char_o && rx_flag_o && rx_data_o == 8'hA5, "R13 char pass", rx_data_o, 8'hA5);
    chk(tick_o && tc_o == 8'h3C, "R13 tick pass", tc_o, 8'h3C);
    ticks(1);
    rx_char = 0; rx_tick = 0;
    chk(running == 1 && err_cred == 0, "R13 char with credit keeps run", running, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule